// File: doc/BRIEF.md
# Ethernet Frame Transmit Engine

This block turns a stream of client frame bytes into a byte-wide transmit stream with an enable and an error strobe, ready for a gigabit media-independent interface. For every frame it sends a seven-byte preamble and a start delimiter first, then the client bytes. Frames shorter than the minimum are filled with zeros, and a CRC-32 frame check sequence is added at the end. After the last check byte the engine holds the line idle for at least the minimum inter-frame gap before it starts the next frame.

The client raises `tx_valid` with the first byte ready. From then on the engine takes one byte per clock while `tx_ack` is high, until a byte marked `tx_last`. If the client cannot supply a byte, it raises `tx_underrun`. The engine then poisons the frame: the error strobe goes high and stays high until that frame ends. A flow-control pulse on `pause_req` queues a pause control frame carrying the given quanta. That frame goes out in the next gap between frames, ahead of any client frame that is waiting.

Top module: `eth_tx_engine`

## Requirements
- R1: Each frame on the line starts with seven bytes of 0x55 and then one byte of 0xD5. The first 0x55 appears in the cycle after the engine samples a start request while idle.
- R2: If fewer than 60 bytes have been sent after the delimiter (client or generated bytes), the engine adds 0x00 bytes until there are 60. `gmii_tx_er` is never high while `gmii_tx_en` is low.
- R3: Four check bytes follow the payload and any padding. They are the CRC-32 (reflected polynomial 0xEDB88320, preset to all ones, result inverted) over every byte after the delimiter, sent least significant byte first.
- R4: After the last check byte, `gmii_tx_en` stays low for at least 12 cycles. A client that is already waiting gets exactly 12 idle cycles.
- R5: A cycle with `tx_underrun` high during the data phase puts a 0x00 byte on the line with `gmii_tx_er` high. No more client bytes are taken. Padding follows as needed, then the check bytes, with `gmii_tx_er` held high up to the frame's last byte.
- R6: A pause frame carries these bytes after the delimiter: 01 80 C2 00 00 01, then `station_addr` with its most significant byte first, then 88 08 00 01, then the quanta with its high byte first. Zeros fill it to 60 bytes, and the check bytes follow as in R3.
- R7: A pause request never interrupts a frame that is in progress. It is sent after the current frame and its gap, and it goes ahead of a client frame that is waiting at the same point.
- R8: `tx_ack` is high only during the data phase, one accepted byte per cycle. It is never high during the preamble, padding, check bytes, gap or a pause frame.
- R9: While `rst_n` is low, the registered outputs `gmii_tx_en`, `gmii_tx_er` and `gmii_txd` are zero and `tx_ack` is low. A pause request made before reset is dropped.
- R10: A client frame of 60 bytes or more goes out with no padding, and `gmii_tx_en` stays high without a break from the first preamble byte to the last check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Client byte currently offered |
| tx_valid | input | 1 | Client has a frame ready (sampled while idle) |
| tx_last | input | 1 | Offered byte is the final byte of the frame |
| tx_underrun | input | 1 | Client cannot supply a byte; corrupt this frame |
| tx_ack | output | 1 | Offered byte consumed at this clock edge |
| pause_req | input | 1 | One-cycle pulse requesting a pause frame |
| pause_quanta | input | 16 | Pause time carried by the requested frame |
| station_addr | input | 48 | Source address placed in pause frames |
| gmii_txd | output | 8 | Line byte |
| gmii_tx_en | output | 1 | Line byte is part of a frame |
| gmii_tx_er | output | 1 | Line byte is deliberately corrupted |

## Verification
The line outputs are registered. A start accepted at clock edge E puts its first preamble byte on the line just after E, and the first client byte seven edges later, when `tx_ack` is high. Each later byte follows one edge after the engine takes it. The last check byte is followed by 12 idle samples. The bench records the line at the falling edge, half a cycle after every update, and rebuilds whole frames from what it sees. It therefore compares byte position, idle-gap length and acknowledge count rather than absolute times. Stimulus and task waits act one nanosecond after a rising edge, so they never race the engine's own sampling.

// File: rtl/eth_tx_pkg.sv
// Shared types and constants for the frame transmit engine.
// Assumes a byte-wide datapath and the reflected CRC-32 used by Ethernet.
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAUSE,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_t;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam logic [31:0] CRC_REFL  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    // Advance a reflected CRC-32 by one byte, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h000000, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
// Running CRC-32 register for the frame check sequence.
// Assumes init and en are never high together with different intent: init wins.
module eth_tx_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    import eth_tx_pkg::*;

    // Preset on init, fold one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

    // R3: the remainder only moves when a byte is folded in.
    a_r3_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !en) |=> $stable(crc_q));

endmodule

// File: rtl/eth_tx_gap_timer.sv
// Down-counter that times the idle spacing after a frame.
// Assumes IFG_BYTES >= 2; done is high whenever no gap is running.
module eth_tx_gap_timer #(
    parameter int IFG_BYTES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int GW = $clog2(IFG_BYTES + 1);

    logic [GW-1:0] remain;

    // Load the gap length, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= GW'(IFG_BYTES - 1);
        end else if (remain != '0) begin
            remain <= remain - GW'(1);
        end
    end

    assign done = (remain == '0);

    // R4: a freshly loaded gap is never reported finished at once.
    a_r4_load_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);

endmodule

// File: rtl/eth_tx_pause_gen.sv
// Byte generator for a pause control frame, indexed from the first byte after
// the delimiter. Assumes the caller stops at the minimum payload length.
module eth_tx_pause_gen #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [47:0]      station_addr,
    input  logic [15:0]      quanta,
    output logic [7:0]       pbyte
);
    int unsigned k;

    // Map byte position to destination, source, type, opcode, quanta or zero fill.
    always_comb begin
        k = 32'(idx);
        case (k)
            0:  pbyte = 8'h01;
            1:  pbyte = 8'h80;
            2:  pbyte = 8'hC2;
            3:  pbyte = 8'h00;
            4:  pbyte = 8'h00;
            5:  pbyte = 8'h01;
            6:  pbyte = station_addr[47:40];
            7:  pbyte = station_addr[39:32];
            8:  pbyte = station_addr[31:24];
            9:  pbyte = station_addr[23:16];
            10: pbyte = station_addr[15:8];
            11: pbyte = station_addr[7:0];
            12: pbyte = 8'h88;
            13: pbyte = 8'h08;
            14: pbyte = 8'h00;
            15: pbyte = 8'h01;
            16: pbyte = quanta[15:8];
            17: pbyte = quanta[7:0];
            default: pbyte = 8'h00;
        endcase
    end

endmodule

// File: rtl/eth_tx_engine.sv
// Frame transmit engine: preamble, client data or pause payload, zero padding,
// CRC-32 check bytes and the inter-frame gap, sequenced by one state machine.
// Assumes the client supplies a byte every cycle of the data phase (or flags
// an underrun), and that pause requests are single-cycle pulses.
module eth_tx_engine #(
    parameter int IFG_BYTES = 12,
    parameter int MIN_DATA  = 60,
    parameter int PRE_LEN   = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  tx_data,
    input  logic        tx_valid,
    input  logic        tx_last,
    input  logic        tx_underrun,
    output logic        tx_ack,
    input  logic        pause_req,
    input  logic [15:0] pause_quanta,
    input  logic [47:0] station_addr,
    output logic [7:0]  gmii_txd,
    output logic        gmii_tx_en,
    output logic        gmii_tx_er
);
    import eth_tx_pkg::*;

    localparam int CNT_W  = $clog2(MIN_DATA + 1);
    localparam int AUX_W  = $clog2(PRE_LEN + 1);
    localparam int IFG_W  = $clog2(IFG_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MIN_DATA - 1);

    tx_state_t        state, state_d;
    logic [AUX_W-1:0] aux, aux_d;
    logic [CNT_W-1:0] cnt, cnt_d, cnt_step;
    logic             corrupt, corrupt_d;
    logic             is_pause, is_pause_d;
    logic             pause_pend;
    logic [15:0]      quanta_q, frame_quanta;

    logic [7:0]  byte_d;
    logic        en_d, er_d;
    logic        crc_init, crc_en, gap_load, gap_done, pause_take, ack_c;
    logic [31:0] crc_q;
    logic [7:0]  pause_byte;
    logic [7:0]  fcs_byte;

    eth_tx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .din   (byte_d),
        .crc_q (crc_q)
    );

    eth_tx_gap_timer #(.IFG_BYTES(IFG_BYTES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .done  (gap_done)
    );

    eth_tx_pause_gen #(.IDX_W(CNT_W)) u_pause (
        .idx          (cnt),
        .station_addr (station_addr),
        .quanta       (frame_quanta),
        .pbyte        (pause_byte)
    );

    // Payload counter saturates at the minimum length.
    assign cnt_step = (cnt < CNT_W'(MIN_DATA)) ? cnt + CNT_W'(1) : cnt;
    // Check bytes go out inverted, lowest byte first.
    assign fcs_byte = ~crc_q[8*aux[1:0] +: 8];

    // Next-state, next line byte and sub-block controls.
    always_comb begin
        state_d    = state;
        aux_d      = aux;
        cnt_d      = cnt;
        corrupt_d  = corrupt;
        is_pause_d = is_pause;
        byte_d     = 8'h00;
        en_d       = 1'b0;
        er_d       = 1'b0;
        crc_init   = 1'b0;
        crc_en     = 1'b0;
        gap_load   = 1'b0;
        pause_take = 1'b0;
        ack_c      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pause_pend || tx_valid) begin
                    pause_take = pause_pend;
                    is_pause_d = pause_pend;
                    byte_d     = PRE_BYTE;
                    en_d       = 1'b1;
                    aux_d      = AUX_W'(1);
                    cnt_d      = '0;
                    corrupt_d  = 1'b0;
                    crc_init   = 1'b1;
                    state_d    = ST_PRE;
                end
            end
            ST_PRE: begin
                en_d  = 1'b1;
                aux_d = aux + AUX_W'(1);
                if (aux == AUX_W'(PRE_LEN)) begin
                    byte_d  = SFD_BYTE;
                    state_d = is_pause ? ST_PAUSE : ST_DATA;
                end else begin
                    byte_d = PRE_BYTE;
                end
            end
            ST_DATA: begin
                en_d   = 1'b1;
                crc_en = 1'b1;
                cnt_d  = cnt_step;
                if (tx_underrun) begin
                    byte_d    = 8'h00;
                    er_d      = 1'b1;
                    corrupt_d = 1'b1;
                end else begin
                    byte_d = tx_data;
                    ack_c  = 1'b1;
                end
                if (tx_underrun || tx_last) begin
                    aux_d   = '0;
                    state_d = (cnt >= LAST_IDX) ? ST_FCS : ST_PAD;
                end
            end
            ST_PAD: begin
                en_d   = 1'b1;
                er_d   = corrupt;
                crc_en = 1'b1;
                cnt_d  = cnt_step;
                if (cnt == LAST_IDX) begin
                    aux_d   = '0;
                    state_d = ST_FCS;
                end
            end
            ST_PAUSE: begin
                en_d   = 1'b1;
                byte_d = pause_byte;
                crc_en = 1'b1;
                cnt_d  = cnt_step;
                if (cnt == LAST_IDX) begin
                    aux_d   = '0;
                    state_d = ST_FCS;
                end
            end
            ST_FCS: begin
                en_d   = 1'b1;
                er_d   = corrupt;
                byte_d = fcs_byte;
                aux_d  = aux + AUX_W'(1);
                if (aux == AUX_W'(3)) begin
                    gap_load = 1'b1;
                    state_d  = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tx_ack = ack_c;

    // State registers and registered line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            aux        <= '0;
            cnt        <= '0;
            corrupt    <= 1'b0;
            is_pause   <= 1'b0;
            gmii_txd   <= 8'h00;
            gmii_tx_en <= 1'b0;
            gmii_tx_er <= 1'b0;
        end else begin
            state      <= state_d;
            aux        <= aux_d;
            cnt        <= cnt_d;
            corrupt    <= corrupt_d;
            is_pause   <= is_pause_d;
            gmii_txd   <= byte_d;
            gmii_tx_en <= en_d;
            gmii_tx_er <= er_d;
        end
    end

    // Latch pause requests; freeze the quanta when a pause frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_pend   <= 1'b0;
            quanta_q     <= 16'h0000;
            frame_quanta <= 16'h0000;
        end else begin
            if (pause_take) begin
                frame_quanta <= quanta_q;
                pause_pend   <= 1'b0;
            end
            if (pause_req) begin
                pause_pend <= 1'b1;
                quanta_q   <= pause_quanta;
            end
        end
    end

    // Idle-run counter used only by the gap assertion below.
    logic [IFG_W-1:0] idle_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_run <= IFG_W'(IFG_BYTES);
        end else if (gmii_tx_en) begin
            idle_run <= '0;
        end else if (idle_run < IFG_W'(IFG_BYTES)) begin
            idle_run <= idle_run + IFG_W'(1);
        end
    end

    // R4: a new frame starts only after the full idle spacing.
    a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmii_tx_en) |-> (idle_run >= IFG_W'(IFG_BYTES)));

    // R1: every frame opens with a preamble byte.
    a_r1_opens_with_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmii_tx_en) |-> (gmii_txd == PRE_BYTE));

    // R5: once a frame is poisoned the error strobe stays up until it ends.
    a_r5_error_held: assert property (@(posedge clk) disable iff (!rst_n)
        (gmii_tx_en && gmii_tx_er) |=> (!gmii_tx_en || gmii_tx_er));

    // R2: the error strobe never appears outside a frame.
    a_r2_er_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        gmii_tx_er |-> gmii_tx_en);

    // R8: client bytes are only taken while a frame is already on the line.
    a_r8_ack_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> gmii_tx_en);

endmodule

// File: tb/tb_eth_tx_engine.sv
`timescale 1ns/1ps
module tb_eth_tx_engine;

    localparam int IFG = 12;
    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    // Table: {length, underrun index (FFFF = none)}
    localparam logic [31:0] VEC [0:7] = '{
        {16'd1,   16'hFFFF},
        {16'd46,  16'hFFFF},
        {16'd59,  16'hFFFF},
        {16'd60,  16'hFFFF},
        {16'd61,  16'hFFFF},
        {16'd120, 16'hFFFF},
        {16'd20,  16'd5},
        {16'd90,  16'd70}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0]  cur_seed = 8'h00;
    int          cur_len = 1;
    int          cur_under = -1;
    int          idx = 0;
    logic        vld = 1'b0;
    logic        start_tg = 1'b0, start_seen = 1'b0;
    logic        preq = 1'b0;
    logic [15:0] pq = 16'h0000;

    logic [7:0] tx_data, gmii_txd;
    logic       tx_last, tx_underrun, tx_ack, gmii_tx_en, gmii_tx_er;

    assign tx_data     = 8'(int'(cur_seed) + idx * 3);
    assign tx_last     = (idx == cur_len - 1);
    assign tx_underrun = (cur_under >= 0) && (idx == cur_under);

    eth_tx_engine dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_data      (tx_data),
        .tx_valid     (vld),
        .tx_last      (tx_last),
        .tx_underrun  (tx_underrun),
        .tx_ack       (tx_ack),
        .pause_req    (preq),
        .pause_quanta (pq),
        .station_addr (STA),
        .gmii_txd     (gmii_txd),
        .gmii_tx_en   (gmii_tx_en),
        .gmii_tx_er   (gmii_tx_er)
    );

    // Client model: raise valid on a start toggle, step the byte index on ack.
    always @(posedge clk) begin
        if (!rst_n) begin
            vld        <= 1'b0;
            start_seen <= start_tg;
            idx        <= 0;
        end else begin
            if (start_tg != start_seen) begin
                vld        <= 1'b1;
                start_seen <= start_tg;
            end else if (tx_ack) begin
                vld <= 1'b0;
            end
            if (tx_ack) idx <= idx + 1;
            else if (vld) idx <= 0;
        end
    end

    int checks = 0, fails = 0;
    logic [7:0] cap [0:255];
    bit   cap_er [0:255];
    int   cap_n = 0, last_gap = 0, idle_cnt = 0, ack_cnt = 0, done_cnt = 0, en_cycles = 0, cycles = 0;
    bit   prev_en = 1'b0;

    logic [7:0] exp_b [0:255];
    bit   exp_er [0:255];
    int   exp_n = 0;

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // Line monitor at the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (gmii_tx_en) begin
            if (!prev_en) begin
                cap_n = 0;
                last_gap = idle_cnt;
                ack_cnt = 0;
            end
            if (cap_n < 256) begin
                cap[cap_n] = gmii_txd;
                cap_er[cap_n] = gmii_tx_er;
            end
            cap_n++;
            idle_cnt = 0;
            en_cycles++;
        end else begin
            if (prev_en) done_cnt++;
            idle_cnt++;
        end
        if (tx_ack) ack_cnt++;
        prev_en = gmii_tx_en;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(logic [7:0] b, bit e);
        exp_b[exp_n] = b;
        exp_er[exp_n] = e;
        exp_n++;
    endtask

    task automatic push_preamble();
        exp_n = 0;
        for (int i = 0; i < 7; i++) push(8'h55, 1'b0);
        push(8'hD5, 1'b0);
    endtask

    // Append the check bytes from an independent bit-serial CRC.
    task automatic add_fcs(bit e);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < exp_n; i++) begin
            c = c ^ {24'h0, exp_b[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) push(c[8*i +: 8], e);
    endtask

    task automatic build_client(int len, logic [7:0] seed, int under);
        bit hit;
        int nd;
        hit = (under >= 0) && (under < len);
        nd = hit ? under + 1 : len;
        push_preamble();
        for (int i = 0; i < nd; i++) begin
            if (hit && i == under) push(8'h00, 1'b1);
            else push(8'(int'(seed) + i * 3), 1'b0);
        end
        while (exp_n < 68) push(8'h00, hit);
        add_fcs(hit);
    endtask

    task automatic build_pause(logic [15:0] q);
        logic [7:0] hdr [0:17];
        hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
                STA[47:40], STA[39:32], STA[31:24], STA[23:16], STA[15:8], STA[7:0],
                8'h88, 8'h08, 8'h00, 8'h01, q[15:8], q[7:0]};
        push_preamble();
        for (int i = 0; i < 18; i++) push(hdr[i], 1'b0);
        while (exp_n < 68) push(8'h00, 1'b0);
        add_fcs(1'b0);
    endtask

    task automatic check_frame(string name, string body_req, int want_acks, int want_gap);
        int n, bad_pre, bad_body, bad_fcs, bad_er, first_b, first_e;
        n = (cap_n < exp_n) ? cap_n : exp_n;
        bad_pre = -1; bad_body = -1; bad_fcs = -1; bad_er = -1;
        for (int i = 0; i < n; i++) begin
            if (cap[i] !== exp_b[i]) begin
                if (i < 8) begin if (bad_pre < 0) bad_pre = i; end
                else if (i >= exp_n - 4) begin if (bad_fcs < 0) bad_fcs = i; end
                else if (bad_body < 0) bad_body = i;
            end
            if (cap_er[i] !== exp_er[i] && bad_er < 0) bad_er = i;
        end
        chk(cap_n == exp_n, body_req, {name, " frame length"}, cap_n, exp_n);
        first_b = (bad_pre < 0) ? 0 : bad_pre;
        chk(bad_pre < 0, "R1", {name, " preamble byte"}, cap[first_b], exp_b[first_b]);
        first_b = (bad_body < 0) ? 8 : bad_body;
        chk(bad_body < 0, body_req, {name, " payload/pad byte"}, cap[first_b], exp_b[first_b]);
        first_b = (bad_fcs < 0) ? 8 : bad_fcs;
        chk(bad_fcs < 0, "R3", {name, " check byte"}, cap[first_b], exp_b[first_b]);
        first_e = (bad_er < 0) ? 0 : bad_er;
        chk(bad_er < 0, "R5", {name, " error strobe at position"}, first_e, -1);
        if (want_acks >= 0) chk(ack_cnt == want_acks, "R8", {name, " ack count"}, ack_cnt, want_acks);
        if (want_gap >= 0) chk(last_gap == want_gap, "R4", {name, " idle gap"}, last_gap, want_gap);
    endtask

    task automatic wait_done(int target);
        int t;
        t = 0;
        while (done_cnt < target && t < 4000) begin
            @(posedge clk); #1;
            t++;
        end
        if (done_cnt < target) chk(1'b0, "R4", "frame end timeout", done_cnt, target);
    endtask

    task automatic start_frame(int len, logic [7:0] seed, int under);
        cur_len = len;
        cur_seed = seed;
        cur_under = under;
        start_tg = ~start_tg;
    endtask

    task automatic pulse_pause(logic [15:0] q);
        @(posedge clk); #1;
        preq = 1'b1;
        pq = q;
        @(posedge clk); #1;
        preq = 1'b0;
    endtask

    initial begin
        int len, und, base, gapw;
        string nm;
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(gmii_tx_en == 1'b0, "R9", "tx_en in reset", gmii_tx_en, 0);
        chk(gmii_tx_er == 1'b0, "R9", "tx_er in reset", gmii_tx_er, 0);
        chk(gmii_txd == 8'h00, "R9", "txd in reset", gmii_txd, 0);
        chk(tx_ack == 1'b0, "R9", "ack in reset", tx_ack, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Table walk: R1, R2, R3, R5, R8, R10; back-to-back gap R4
        for (int v = 0; v < 8; v++) begin
            len = int'(VEC[v][31:16]);
            und = (VEC[v][15:0] == 16'hFFFF) ? -1 : int'(VEC[v][15:0]);
            nm = $sformatf("vec%0d len%0d", v, len);
            build_client(len, 8'(8'h10 + v * 37), und);
            base = done_cnt;
            start_frame(len, 8'(8'h10 + v * 37), und);
            wait_done(base + 1);
            gapw = (v == 0) ? -1 : IFG;
            check_frame(nm, (len >= 60) ? "R10" : "R2", (und >= 0) ? und : len, gapw);
        end

        // R7 / R6: pause requested mid-frame waits, then beats a waiting client
        build_client(80, 8'h3C, -1);
        base = done_cnt;
        start_frame(80, 8'h3C, -1);
        repeat (20) @(posedge clk);
        #1;
        pulse_pause(16'hA55A);
        wait_done(base + 1);
        check_frame("client before pause R7", "R10", 80, IFG);
        start_frame(30, 8'h99, -1);
        wait_done(base + 2);
        build_pause(16'hA55A);
        check_frame("pause frame R6 R7", "R6", 0, IFG);
        wait_done(base + 3);
        build_client(30, 8'h99, -1);
        check_frame("client after pause R7", "R2", 30, IFG);

        // R9: reset mid-frame drops the frame and a pending pause
        base = done_cnt;
        start_frame(100, 8'h44, -1);
        repeat (30) @(posedge clk);
        #1;
        pulse_pause(16'h1234);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(gmii_tx_en == 1'b0, "R9", "tx_en after mid-frame reset", gmii_tx_en, 0);
        chk(tx_ack == 1'b0, "R9", "ack after mid-frame reset", tx_ack, 0);
        rst_n = 1'b1;
        base = en_cycles;
        repeat (80) @(posedge clk);
        #1;
        chk(en_cycles == base, "R9", "line activity after reset (pause dropped)", en_cycles - base, 0);

        // Recovery after reset
        build_client(10, 8'h77, -1);
        base = done_cnt;
        start_frame(10, 8'h77, -1);
        wait_done(base + 1);
        check_frame("post-reset frame R9", "R2", 10, -1);

        summary_and_end();
    end

endmodule